// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block holds received characters for a 16550-style serial port between the receive shift logic and the data port read by software. Bytes arrive on a strobe with their data. They leave in arrival order on a read strobe. A control byte write selects FIFO or single-holding-register operation, flushes the receive or transmit queues, and sets the fill level at which the receive data is counted as ready for service.

Alongside the data path the block keeps a character timer. The timer raises a pending flag when data has been sitting in the queue for four character times with no new arrival and no read. The block also reports a flow-control credit: the number of bytes the receiver may still deliver before it should pause. This credit is limited by the selected fill level, so the queue does not fill completely before software has a chance to respond.

Top module: `uart_rx_fifo`

## Requirements
- R1: The control byte uses bit 0 for queue enable, bit 1 for receive flush, bit 2 for transmit flush, bit 3 for DMA-mode select and bits 7:6 for the fill level. Only the bits under mask 0xC9 are kept in `fcr_bits`, which is 0x00 after reset.
- R2: The fill level is taken from bits 7:6 only on a write with bit 0 set: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 (DEPTH-2). After reset it is 1.
- R3: A write that changes bit 0 performs both flushes. A write equal to the stored `fcr_bits` value changes nothing. A transmit flush appears as a one-cycle `tx_flush` pulse in the cycle after the write.
- R4: A receive flush empties the queue and clears the timeout flag and the break flag.
- R5: Bytes are read in arrival order. `rd_data` shows the oldest byte while `rd_en` is high, and the byte is removed at that clock edge. `data_ready` is high exactly when `fill_count` is nonzero.
- R6: A read of an empty queue returns 0 and leaves the count unchanged.
- R7: A byte that arrives while the queue is at capacity, with no read in the same cycle, is dropped, and `overrun` pulses in the following cycle. A read and an arrival in the same cycle on a non-empty queue leave the count unchanged.
- R8: Each accepted byte, and each read that leaves data behind, restarts the timer. `timeout_pend` rises exactly 4×`char_cycles` clock edges after the restarting edge if data is present then.
- R9: Any read that removes a byte clears `timeout_pend`.
- R10: With the queue enabled, `credit` is 0 when the queue is full, the fill level minus the count while the count is at or below the fill level, and 1 otherwise.
- R11: A `rx_break` pulse sets `break_flag`. The flag stays set until a read empties the queue.
- R12: With the queue disabled, capacity is one byte, `credit` is 1 when empty and 0 otherwise, and the timer never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fcr_we | input | 1 | Control byte write strobe |
| fcr_wdata | input | 8 | Control byte value |
| char_cycles | input | CHAR_W | Clock cycles per character time |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DW | Received byte |
| rx_break | input | 1 | Break condition detected |
| rd_en | input | 1 | Data port read strobe |
| rd_data | output | DW | Oldest byte, or 0 when empty |
| data_ready | output | 1 | Queue holds data |
| fill_count | output | CW | Bytes held |
| trig_level | output | CW | Decoded fill level |
| fifo_en | output | 1 | Queue mode enabled |
| fcr_bits | output | 8 | Retained control bits |
| tx_flush | output | 1 | Transmit flush pulse |
| timeout_pend | output | 1 | Character timeout pending |
| credit | output | CW | Bytes the receiver may still deliver |
| overrun | output | 1 | Dropped-byte pulse |
| break_flag | output | 1 | Break seen since last emptying read |

## Verification
The bench samples the timeout flag one edge before and exactly at the 4×`char_cycles` boundary. A timer that is off by one, or one that a read leaving data behind does not restart, is caught there. Arrivals at full capacity, a read and an arrival together both on a full and on an empty queue, and a repeat of the stored control value are all driven. A design that loses the paired byte, returns stale data on an empty read, or flushes on a repeated write would upset the scoreboard order or the count. The credit is checked at a fill level of one, where it drops to zero at the level and returns to one above it. A design that saturates at zero or advertises free space would fail that check. The break flag is followed through fifteen reads that leave data behind and one final read that empties the queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Fill level chosen by the two level-select bits, scaled to the depth.
    function automatic int unsigned level_of(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [7:0]    wdata,
    output logic [7:0]    bits,
    output logic [CW-1:0] level,
    output logic          rx_flush,
    output logic          tx_flush
);
    import rxq_pkg::*;

    typedef struct packed {
        logic [7:0]    bits;
        logic [CW-1:0] level;
        logic          txf;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [7:0] eff;

    always_comb begin
        st_d     = st_q;
        st_d.txf = 1'b0;
        rx_flush = 1'b0;
        eff      = wdata;
        if (we && (wdata != st_q.bits)) begin
            if (wdata[0] != st_q.bits[0]) begin
                eff[1] = 1'b1;
                eff[2] = 1'b1;
            end
            rx_flush = eff[1];
            st_d.txf = eff[2];
            if (eff[0]) begin
                st_d.level = CW'(level_of(eff[7:6], DEPTH));
            end
            st_d.bits = eff & 8'hC9;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bits: 8'h00, level: CW'(1), txf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bits     = st_q.bits;
    assign level    = st_q.level;
    assign tx_flush = st_q.txf;

    AST_KEPT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bits & 8'h36) == 8'h00);  // R1
    AST_REPEAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata == st_q.bits) |=> (!tx_flush && $stable(st_q.bits)));  // R3

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          fifo_en,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          overrun
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
    } store_t;

    store_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic [CW-1:0] cap;

    always_comb begin
        cap     = fifo_en ? CW'(DEPTH) : CW'(1);
        pop_ok  = rd_req && (st_q.cnt != '0) && !flush;
        push_ok = wr_req && !flush && ((st_q.cnt < cap) || pop_ok);
        st_d     = st_q;
        st_d.ovr = wr_req && !flush && !push_ok;
        if (push_ok) st_d.wp = st_q.wp + AW'(1);
        if (pop_ok)  st_d.rp = st_q.rp + AW'(1);
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= wr_data;
    end

    assign head    = (st_q.cnt != '0) ? mem_q[st_q.rp] : '0;
    assign count   = st_q.cnt;
    assign overrun = st_q.ovr;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));  // R5
    AST_DROP_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> ($past(st_q.cnt) == $past(cap)));  // R7
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && st_q.cnt == '0) |-> (head == '0));  // R6

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int unsigned CHAR_W = 16,
    localparam int unsigned TW    = CHAR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              flush,
    input  logic              restart,
    input  logic              pop,
    input  logic              have_data,
    input  logic [CHAR_W-1:0] char_cycles,
    output logic              pending
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          armed;
        logic          pend;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [TW-1:0] limit;

    always_comb begin
        limit = (char_cycles == '0) ? TW'(1) : {char_cycles, 2'b00};
        st_d  = st_q;
        if (st_q.armed) begin
            if (st_q.cnt == limit - TW'(1)) begin
                st_d.armed = 1'b0;
                if (have_data) st_d.pend = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + TW'(1);
            end
        end
        if (pop) st_d.pend = 1'b0;
        if (restart) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end
        if (flush || !enable) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !pending);  // R9
    AST_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(have_data));  // R8
    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pending);  // R12

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DW     = 8,
    parameter int unsigned CHAR_W = 16,
    localparam int unsigned CW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fcr_we,
    input  logic [7:0]        fcr_wdata,
    input  logic [CHAR_W-1:0] char_cycles,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_data,
    input  logic              rx_break,
    input  logic              rd_en,
    output logic [DW-1:0]     rd_data,
    output logic              data_ready,
    output logic [CW-1:0]     fill_count,
    output logic [CW-1:0]     trig_level,
    output logic              fifo_en,
    output logic [7:0]        fcr_bits,
    output logic              tx_flush,
    output logic              timeout_pend,
    output logic [CW-1:0]     credit,
    output logic              overrun,
    output logic              break_flag
);
    typedef struct packed {
        logic brk;
    } top_t;

    top_t st_d, st_q;
    logic rx_flush, push_ok, pop_ok, restart;
    logic [CW-1:0] left;

    rxq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .we(fcr_we), .wdata(fcr_wdata),
        .bits(fcr_bits), .level(trig_level), .rx_flush(rx_flush), .tx_flush(tx_flush)
    );

    assign fifo_en = fcr_bits[0];

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .fifo_en(fifo_en),
        .wr_req(rx_valid), .wr_data(rx_data), .rd_req(rd_en),
        .head(rd_data), .count(fill_count), .push_ok(push_ok), .pop_ok(pop_ok),
        .overrun(overrun)
    );

    always_comb begin
        left    = fill_count - CW'(pop_ok) + CW'(push_ok);
        restart = push_ok || (pop_ok && left != '0);
    end

    rxq_timer #(.CHAR_W(CHAR_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .enable(fifo_en), .flush(rx_flush),
        .restart(restart), .pop(pop_ok), .have_data(fill_count != '0),
        .char_cycles(char_cycles), .pending(timeout_pend)
    );

    always_comb begin
        st_d = st_q;
        if (pop_ok && left == '0) st_d.brk = 1'b0;
        if (rx_break)             st_d.brk = 1'b1;
        if (rx_flush)             st_d.brk = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign break_flag = st_q.brk;
    assign data_ready = (fill_count != '0);

    always_comb begin
        if (!fifo_en)                     credit = (fill_count == '0) ? CW'(1) : '0;
        else if (fill_count == CW'(DEPTH)) credit = '0;
        else if (fill_count <= trig_level) credit = trig_level - fill_count;
        else                               credit = CW'(1);
    end

    AST_CREDIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == CW'(DEPTH)) |-> (credit == '0));  // R10
    AST_TOGGLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != $past(fifo_en)) |-> (fill_count == '0 && tx_flush));  // R3
    AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rd_en && fill_count != '0 && !fcr_we) |=> $stable(fill_count));  // R7
    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (fill_count == '0 && !timeout_pend && !break_flag));  // R4

endmodule

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fcr_we = 1'b0;
    logic [7:0] fcr_wdata = '0;
    logic [15:0] char_cycles = 16'd2;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_break = 1'b0;
    logic rd_en = 1'b0;
    logic [7:0] rd_data;
    logic data_ready, fifo_en, tx_flush, timeout_pend, overrun, break_flag;
    logic [4:0] fill_count, trig_level, credit;
    logic [7:0] fcr_bits;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] sb[$];
    logic [7:0] fcr_m = 8'h00;
    int trig_m = 1;
    int exp_tx = 0;
    logic [7:0] e;
    string rtag;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_fifo i_uart_rx_fifo (
        .clk(clk), .rst_n(rst_n), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
        .char_cycles(char_cycles), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .rd_en(rd_en), .rd_data(rd_data),
        .data_ready(data_ready), .fill_count(fill_count), .trig_level(trig_level),
        .fifo_en(fifo_en), .fcr_bits(fcr_bits), .tx_flush(tx_flush),
        .timeout_pend(timeout_pend), .credit(credit), .overrun(overrun),
        .break_flag(break_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: each read pops the scoreboard, or expects 0 on an empty queue.
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            rtag = (sb.size() > 0) ? "R5 read order" : "R6 empty read";
            e = (sb.size() > 0) ? sb.pop_front() : 8'h00;
            chk(rtag, int'(rd_data), int'(e));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int cap_m();
        return fcr_m[0] ? DEPTH : 1;
    endfunction

    task automatic push(input logic [7:0] d);
        bit fits;
        fits = (sb.size() < cap_m());
        rx_valid = 1'b1;
        rx_data  = d;
        step();
        rx_valid = 1'b0;
        if (fits) sb.push_back(d);
        chk("R7 overrun pulse", int'(overrun), fits ? 0 : 1);
        chk("R5 fill count", int'(fill_count), sb.size());
    endtask

    task automatic rd();
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
        chk("R5 fill after read", int'(fill_count), sb.size());
    endtask

    task automatic both(input logic [7:0] d);
        rx_valid = 1'b1;
        rd_en    = 1'b1;
        rx_data  = d;
        step();
        rx_valid = 1'b0;
        rd_en    = 1'b0;
        sb.push_back(d);
        chk("R7 paired overrun", int'(overrun), 0);
    endtask

    task automatic fcr(input logic [7:0] v);
        logic [7:0] vv;
        vv = v;
        exp_tx = 0;
        if (v != fcr_m) begin
            if (vv[0] != fcr_m[0]) vv = vv | 8'h06;
            if (vv[1]) sb.delete();
            exp_tx = vv[2];
            if (vv[0]) begin
                case (vv[7:6])
                    2'b00: trig_m = 1;
                    2'b01: trig_m = 4;
                    2'b10: trig_m = 8;
                    default: trig_m = 14;
                endcase
            end
            fcr_m = vv & 8'hC9;
        end
        fcr_we = 1'b1;
        fcr_wdata = v;
        step();
        fcr_we = 1'b0;
        chk("R1 kept bits", int'(fcr_bits), int'(fcr_m));
        chk("R2 fill level", int'(trig_level), trig_m);
        chk("R3 tx flush pulse", int'(tx_flush), exp_tx);
        chk("R3 fill after write", int'(fill_count), sb.size());
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        // Reset state
        chk("R1 reset bits", int'(fcr_bits), 0);
        chk("R2 reset level", int'(trig_level), 1);
        chk("R5 reset ready", int'(data_ready), 0);
        chk("R12 reset credit", int'(credit), 1);
        chk("R8 reset pending", int'(timeout_pend), 0);
        chk("R11 reset break", int'(break_flag), 0);
        rd();  // R6 empty read

        // Disabled mode: single holding slot
        push(8'h11);
        chk("R12 credit when held", int'(credit), 0);
        chk("R5 ready", int'(data_ready), 1);
        push(8'h22);  // R7 dropped
        step();
        chk("R7 pulse length", int'(overrun), 0);
        repeat (20) step();
        chk("R12 no timeout", int'(timeout_pend), 0);
        rd();

        // Enable with all flushes, level 14
        fcr(8'hCF);
        step();
        chk("R3 pulse one cycle", int'(tx_flush), 0);
        chk("R10 credit empty", int'(credit), 14);
        push(8'hA1);
        push(8'hA2);
        push(8'hA3);
        chk("R10 credit below level", int'(credit), 11);
        repeat (7) step();
        chk("R8 before expiry", int'(timeout_pend), 0);
        step();
        chk("R8 at expiry", int'(timeout_pend), 1);
        rd();
        chk("R9 read clears", int'(timeout_pend), 0);
        repeat (7) step();
        chk("R8 restart by read", int'(timeout_pend), 0);
        step();
        chk("R8 restarted expiry", int'(timeout_pend), 1);

        // Repeated value: no effect
        fcr(8'hC9);
        chk("R3 repeat keeps pending", int'(timeout_pend), 1);
        rx_break = 1'b1;
        step();
        rx_break = 1'b0;
        chk("R11 break set", int'(break_flag), 1);
        fcr(8'hCB);  // receive flush only
        chk("R4 pending cleared", int'(timeout_pend), 0);
        chk("R4 break cleared", int'(break_flag), 0);

        // Level decode
        fcr(8'h41);
        chk("R10 credit level 4", int'(credit), 4);
        fcr(8'h81);
        fcr(8'h01);
        push(8'h01);
        chk("R10 credit at level", int'(credit), 0);
        push(8'h02);
        chk("R10 credit above level", int'(credit), 1);
        for (int i = 0; i < 14; i++) push(8'h10 + 8'(i));
        chk("R10 credit full", int'(credit), 0);
        push(8'hEE);  // R7 dropped at full
        both(8'h77);
        chk("R7 paired count", int'(fill_count), 16);

        // Break held through reads that leave data
        rx_break = 1'b1;
        step();
        rx_break = 1'b0;
        for (int i = 0; i < 15; i++) rd();
        chk("R11 break held", int'(break_flag), 1);
        chk("R5 ready held", int'(data_ready), 1);
        rd();
        chk("R11 break cleared", int'(break_flag), 0);
        chk("R5 ready cleared", int'(data_ready), 0);

        // Paired access on an empty queue
        both(8'h55);
        chk("R6 paired on empty", int'(fill_count), 1);
        rd();

        // Disable: toggle forces both flushes
        push(8'h66);
        fcr(8'h00);
        chk("R3 disabled", int'(fifo_en), 0);
        chk("R12 credit after disable", int'(credit), 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule